// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a translation miss by reading one entry from a flat page table held in memory. A requester hands over a virtual page number, the physical base address of the table, and whether the missing access is a store. The walker computes where the entry lives, which is the base plus four bytes per virtual page. It issues one read on a valid/ready memory request channel and waits for the single-cycle read response.

A returned entry whose present bit is clear ends the walk with a one-cycle fault pulse. A present entry ends it with a one-cycle done pulse, and the refill outputs then carry the physical page number and the referenced and dirty bits for the translation cache. If the entry's status bits must change, the walker first stores the updated entry back to the same address. This happens when a load finds the referenced bit clear, or when a store finds either the referenced bit or the dirty bit clear. The page offset (the low 12 address bits of a 4 KB page) never passes through the walker.

Top module: `ptw_walker`

## Requirements
- R1: Each accepted walk issues exactly one read, whose address equals `pt_base + 4*walk_vpn` modulo 2^PA_W, using the values present when the walk was accepted.
- R2: Entry layout: bit 0 is present, bit 1 is referenced, bit 2 is dirty, bits [12 +: PPN_W] hold the physical page number, and all other bits are carried unchanged.
- R3: A returned entry with bit 0 clear produces one fault pulse, no done pulse and no memory write.
- R4: A load walk whose entry has the present bit set and bit 1 clear stores the entry back to the same address with bit 1 set and every other bit unchanged, before done.
- R5: A store walk whose entry has the present bit set and bit 1 or bit 2 clear stores the entry back with bits 1 and 2 both set, before done.
- R6: A present entry that needs no status change causes no memory write, and done pulses in the cycle after the read response.
- R7: `walk_ready` is high only while idle, and a walk request made while busy is ignored.
- R8: While a memory request is offered and not accepted, it stays valid and its address, direction and data stay unchanged.
- R9: After reset the walker is idle: `walk_ready` high, and no memory request, done or fault.
- R10: Each accepted walk produces exactly one single-cycle pulse, either done or fault, never both. At done, `refill_ppn`, `refill_ref` and `refill_dirty` show the entry as last written (referenced bit set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_valid | input | 1 | Walk request |
| walk_ready | output | 1 | Walker idle, request accepted this cycle |
| walk_vpn | input | VPN_W | Virtual page number to translate |
| walk_write | input | 1 | Missing access is a store |
| pt_base | input | PA_W | Physical byte address of the page table |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write (entry update) |
| mem_req_addr | output | PA_W | Entry byte address |
| mem_req_wdata | output | 32 | Entry value to store |
| mem_rsp_valid | input | 1 | Read data returned (one cycle) |
| mem_rsp_data | input | 32 | Returned page table entry |
| walk_done | output | 1 | One-cycle pulse: translation ready for refill |
| walk_fault | output | 1 | One-cycle pulse: page not present |
| refill_ppn | output | PPN_W | Physical page number |
| refill_ref | output | 1 | Referenced bit of the refill entry |
| refill_dirty | output | 1 | Dirty bit of the refill entry |

## Verification
The read request is offered in the cycle after acceptance and is held until ready. The outcome follows the read response by one cycle when no update is needed. When an update is needed, it follows by two cycles plus any cycles the write waits for ready. The bench's memory model timestamps each response on a cycle counter and compares the observed pulse cycle with that arithmetic for every combination of present/referenced/dirty bits, load or store, response latency and ready stalls. All sampling happens one nanosecond after the falling edge, so every registered result has settled.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int PTE_W     = 32;
    localparam int PTE_BYTES = 4;
    localparam int PTE_SHIFT = $clog2(PTE_BYTES);
    localparam int PPN_LSB   = 12;
    localparam int BIT_PRES  = 0;
    localparam int BIT_REF   = 1;
    localparam int BIT_DIRTY = 2;

    typedef logic [PTE_W-1:0] pte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_UPD,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic present;
        logic refd;
        logic dirty;
    } pte_flags_t;

    function automatic pte_flags_t pte_flags(input pte_t e);
        pte_flags_t f;
        f.present = e[BIT_PRES];
        f.refd    = e[BIT_REF];
        f.dirty   = e[BIT_DIRTY];
        return f;
    endfunction

    function automatic pte_t pte_mark(input pte_t e, input logic is_store);
        pte_t m;
        m = e;
        m[BIT_REF] = 1'b1;
        if (is_store) m[BIT_DIRTY] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PA_W  = 32
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  addr
);
    logic [PA_W-1:0] offset;

    always_comb begin
        offset = PA_W'(vpn) << PTE_SHIFT;
        addr   = base + offset;
    end
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
(
    input  pte_t entry,
    input  logic is_store,
    output logic present,
    output logic need_wb,
    output pte_t marked
);
    pte_flags_t f;

    always_comb begin
        f       = pte_flags(entry);
        present = f.present;
        need_wb = f.present && (!f.refd || (is_store && !f.dirty));
        marked  = pte_mark(entry, is_store);
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        walk_valid,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic        present,
    input  logic        need_wb,
    output logic        walk_ready,
    output logic        accept,
    output logic        capture,
    output logic        req_valid,
    output logic        req_write,
    output logic        done,
    output logic        fault
);
    walk_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (walk_valid) state_nx = ST_REQ;
            ST_REQ:   if (mem_req_ready) state_nx = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) begin
                          if (!present)    state_nx = ST_FAULT;
                          else if (need_wb) state_nx = ST_UPD;
                          else              state_nx = ST_DONE;
                      end
            ST_UPD:   if (mem_req_ready) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        walk_ready = (state == ST_IDLE);
        accept     = walk_ready && walk_valid;
        capture    = (state == ST_WAIT) && mem_rsp_valid;
        req_valid  = (state == ST_REQ) || (state == ST_UPD);
        req_write  = (state == ST_UPD);
        done       = (state == ST_DONE);
        fault      = (state == ST_FAULT);
    end

    // R10: done and fault are exclusive and each lasts one cycle
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r10_fault_pulse: assert property (@(posedge clk) disable iff (rst)
        fault |=> !fault);
    // R7: busy right after acceptance
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (walk_valid && walk_ready) |=> !walk_ready);
    // R3: a fault is never accompanied by a memory request
    a_r3_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        fault |-> !req_valid);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PA_W  = 32,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             walk_valid,
    output logic             walk_ready,
    input  logic [VPN_W-1:0] walk_vpn,
    input  logic             walk_write,
    input  logic [PA_W-1:0]  pt_base,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [PA_W-1:0]  mem_req_addr,
    output logic [31:0]      mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [31:0]      mem_rsp_data,
    output logic             walk_done,
    output logic             walk_fault,
    output logic [PPN_W-1:0] refill_ppn,
    output logic             refill_ref,
    output logic             refill_dirty
);
    logic [VPN_W-1:0] vpn_q;
    logic [PA_W-1:0]  base_q;
    logic             store_q;
    pte_t             pte_q;

    logic accept, capture, present, need_wb;
    pte_t marked;

    ptw_ctrl ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .walk_valid    (walk_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .present       (present),
        .need_wb       (need_wb),
        .walk_ready    (walk_ready),
        .accept        (accept),
        .capture       (capture),
        .req_valid     (mem_req_valid),
        .req_write     (mem_req_write),
        .done          (walk_done),
        .fault         (walk_fault)
    );

    ptw_addr_gen #(.VPN_W(VPN_W), .PA_W(PA_W)) addr_i (
        .base (base_q),
        .vpn  (vpn_q),
        .addr (mem_req_addr)
    );

    ptw_pte_check check_i (
        .entry    (mem_rsp_data),
        .is_store (store_q),
        .present  (present),
        .need_wb  (need_wb),
        .marked   (marked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vpn_q   <= '0;
            base_q  <= '0;
            store_q <= 1'b0;
            pte_q   <= '0;
        end else begin
            if (accept) begin
                vpn_q   <= walk_vpn;
                base_q  <= pt_base;
                store_q <= walk_write;
            end
            if (capture) pte_q <= present ? marked : mem_rsp_data;
        end
    end

    always_comb begin
        mem_req_wdata = pte_q;
        refill_ppn    = pte_q[PPN_LSB +: PPN_W];
        refill_ref    = pte_q[BIT_REF];
        refill_dirty  = pte_q[BIT_DIRTY];
    end

    // R8: an offered request holds until accepted
    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) &&
             $stable(mem_req_write) && $stable(mem_req_wdata)));
    // R4: every entry update carries the referenced bit
    a_r4_update_ref: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[BIT_REF]);
    // R5: a store walk's update carries the dirty bit
    a_r5_update_dirty: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write && store_q) |-> mem_req_wdata[BIT_DIRTY]);
    // R10: a done pulse follows a present entry
    a_r10_done_present: assert property (@(posedge clk) disable iff (rst)
        walk_done |-> (pte_q[BIT_PRES] && refill_ref));
endmodule

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
    localparam int VPN_W = 20;
    localparam int PA_W  = 32;
    localparam int PPN_W = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic walk_valid = 1'b0;
    logic walk_ready;
    logic [VPN_W-1:0] walk_vpn = '0;
    logic walk_write = 1'b0;
    logic [PA_W-1:0] pt_base = '0;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic mem_req_write;
    logic [PA_W-1:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic walk_done, walk_fault;
    logic [PPN_W-1:0] refill_ppn;
    logic refill_ref, refill_dirty;

    int n_chk = 0;
    int n_bad = 0;

    // memory model state
    logic [31:0] table_pte = '0;
    int lat_cfg = 0, stall_cfg = 0;
    int cyc = 0, rsp_cyc = 0;
    int reads = 0, writes = 0;
    logic [31:0] rd_addr = '0, wr_addr = '0, wr_data = '0;
    int stall_cnt = 0, rsp_cnt = 0;
    bit rsp_pending = 0;

    always #2 clk = ~clk;

    ptw_walker #(.VPN_W(VPN_W), .PA_W(PA_W), .PPN_W(PPN_W)) dut_i (
        .clk(clk), .rst(rst),
        .walk_valid(walk_valid), .walk_ready(walk_ready),
        .walk_vpn(walk_vpn), .walk_write(walk_write), .pt_base(pt_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .walk_done(walk_done), .walk_fault(walk_fault),
        .refill_ppn(refill_ppn), .refill_ref(refill_ref),
        .refill_dirty(refill_dirty)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        mem_rsp_valid = 1'b0;
        if (rst) begin
            mem_req_ready = 1'b0;
            rsp_pending = 0;
            stall_cnt = 0;
        end else begin
            if (rsp_pending) begin
                if (rsp_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = table_pte;
                    rsp_pending = 0;
                    rsp_cyc = cyc;
                end else rsp_cnt = rsp_cnt - 1;
            end
            if (mem_req_valid) begin
                if (stall_cnt < stall_cfg) begin
                    mem_req_ready = 1'b0;
                    stall_cnt = stall_cnt + 1;
                end else begin
                    mem_req_ready = 1'b1;
                    stall_cnt = 0;
                    if (mem_req_write) begin
                        writes = writes + 1;
                        wr_addr = mem_req_addr;
                        wr_data = mem_req_wdata;
                    end else begin
                        reads = reads + 1;
                        rd_addr = mem_req_addr;
                        rsp_pending = 1;
                        rsp_cnt = lat_cfg;
                    end
                end
            end else mem_req_ready = 1'b0;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_walk(input logic [VPN_W-1:0] vpn, input logic [31:0] base,
                            input bit st, input logic [31:0] pte,
                            input int lat, input int stall);
        int r0, w0, n_done, n_fault, done_cyc, after;
        bit present, need_wb;
        logic [31:0] exp_new, exp_addr;
        logic [PPN_W-1:0] got_ppn;
        logic got_ref, got_dirty;
        present  = pte[0];
        need_wb  = present && (!pte[1] || (st && !pte[2]));
        exp_new  = pte | 32'h2 | (st ? 32'h4 : 32'h0);
        exp_addr = base + {vpn, 2'b00};
        tick();
        table_pte = pte; lat_cfg = lat; stall_cfg = stall;
        r0 = reads; w0 = writes;
        check(walk_ready == 1'b1, "R7", "ready while idle", 32'(walk_ready), 1);
        walk_valid = 1'b1; walk_vpn = vpn; walk_write = st; pt_base = base;
        tick();
        check(walk_ready == 1'b0, "R7", "ready while busy", 32'(walk_ready), 0);
        // keep requesting with other values while busy: must be ignored
        walk_vpn = ~vpn; walk_write = ~st; pt_base = ~base;
        n_done = 0; n_fault = 0; done_cyc = 0; after = -1;
        got_ppn = '0; got_ref = 0; got_dirty = 0;
        for (int i = 0; i < 60 && after != 0; i++) begin
            if (walk_done) begin
                n_done++; done_cyc = cyc;
                got_ppn = refill_ppn; got_ref = refill_ref; got_dirty = refill_dirty;
            end
            if (walk_fault) begin n_fault++; done_cyc = cyc; end
            if ((walk_done || walk_fault) && after < 0) begin
                walk_valid = 1'b0;
                after = 4;
            end else if (after > 0) after--;
            if (after != 0) tick();
        end
        check(reads - r0 == 1, "R1", "read count", 32'(reads - r0), 1);
        check(rd_addr == exp_addr, "R1", "read address", rd_addr, exp_addr);
        check(n_done + n_fault == 1, "R10", "outcome pulses", 32'(n_done + n_fault), 1);
        if (!present) begin
            check(n_fault == 1, "R3", "fault pulse", 32'(n_fault), 1);
            check(writes - w0 == 0, "R3", "no write on fault", 32'(writes - w0), 0);
            check(done_cyc - rsp_cyc == 1, "R3", "fault latency", 32'(done_cyc - rsp_cyc), 1);
        end else begin
            check(n_done == 1, "R2", "done pulse", 32'(n_done), 1);
            check(got_ppn == exp_new[12 +: PPN_W], "R2", "refill ppn", 32'(got_ppn),
                  32'(exp_new[12 +: PPN_W]));
            check(got_ref == 1'b1, "R10", "refill ref", 32'(got_ref), 1);
            check(got_dirty == exp_new[2], "R10", "refill dirty", 32'(got_dirty), 32'(exp_new[2]));
            if (need_wb) begin
                check(writes - w0 == 1, st ? "R5" : "R4", "write count", 32'(writes - w0), 1);
                check(wr_addr == exp_addr, st ? "R5" : "R4", "write address", wr_addr, exp_addr);
                check(wr_data == exp_new, st ? "R5" : "R4", "write data", wr_data, exp_new);
                check(done_cyc - rsp_cyc == 2 + stall, "R8", "done after held write",
                      32'(done_cyc - rsp_cyc), 32'(2 + stall));
            end else begin
                check(writes - w0 == 0, "R6", "no write", 32'(writes - w0), 0);
                check(done_cyc - rsp_cyc == 1, "R6", "done latency", 32'(done_cyc - rsp_cyc), 1);
            end
        end
    endtask

    initial begin
        logic [VPN_W-1:0] vpns [6];
        vpns[0] = 20'h00000; vpns[1] = 20'h00001; vpns[2] = 20'h00005;
        vpns[3] = 20'hFFFFF; vpns[4] = 20'h12345; vpns[5] = 20'h80000;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R9: idle after reset
        check(walk_ready == 1'b1, "R9", "reset ready", 32'(walk_ready), 1);
        check(mem_req_valid == 1'b0, "R9", "reset request", 32'(mem_req_valid), 0);
        check(walk_done == 1'b0 && walk_fault == 1'b0, "R9", "reset pulses",
              32'({walk_done, walk_fault}), 0);
        for (int v = 0; v < 6; v++) begin
            for (int c = 0; c < 16; c++) begin
                logic [31:0] base, pte;
                logic [19:0] ppn;
                base = 32'h0040_0000 * (v + 1) + 32'(v * 4);
                if (v == 3) base = 32'hFFFF_F000;
                ppn  = vpns[v] ^ 20'(c * 32'h1111) ^ 20'hA5A5A;
                pte  = {ppn, 9'(c * 7 + v), 3'(c)};
                run_walk(vpns[v], base, c[3], pte, (v + c) % 4, c % 3);
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule